// File: doc/BRIEF.md
# Stereo Soft Volume and Mute Ramp Controller

This block sits in front of the gain multiplier of a two-channel DAC data path. For each channel it takes a requested attenuation and a mute request, and it produces the attenuation code that is actually applied. Attenuation is an unsigned code in 0.5 dB units. The all-ones code (255 with the default width) means full mute. The applied code is moved toward the wanted value in one of two ways: one code at a time at a rate paced by a once-per-frame strobe, or in a single jump timed to a zero crossing of that channel's audio. A long run of zero-valued samples on a channel mutes that channel automatically, unless the feature is turned off.

Each channel has its own state machine with three states. ST_IDLE means the applied code equals the goal. ST_RAMP means the code is stepping toward the goal. ST_WAIT_ZC means a jump is pending until the next zero crossing. The transitions are as follows. ST_IDLE goes to ST_RAMP or to ST_WAIT_ZC when the goal differs from the applied code; the mode bit picks which. ST_RAMP and ST_WAIT_ZC swap with each other when the mode bit changes while a change is pending. ST_RAMP goes back to ST_IDLE when the goal is reached. ST_WAIT_ZC goes back to ST_IDLE once the jump is taken. Any state goes to ST_IDLE on power-down.

The goal is full mute while power-down, the channel's mute input or the channel's auto-mute is active. Otherwise it is the target code. The dB-to-linear conversion and the multiplier lie outside this block.

Top module: `softvol_ctrl`

## Requirements
- R1: After reset both applied attenuation outputs are 0 (0 dB) and both channels are in ST_IDLE.
- R2: With zc_mode=0 and pwr_down=0, an applied code changes only in the cycle after a frame_stb, and by exactly one code (0.5 dB) toward its goal.
- R3: Ramp pacing uses one step per 8, 4, 16 or 32 frame strobes for rate_sel 0, 1, 2 and 3. The first step lands on the rate's Nth strobe counted after the goal changes.
- R4: With zc_mode=1 the applied code jumps to the goal on the first frame strobe whose sample is exactly zero or whose sign bit (MSB) differs from the sign bit of that channel's sample at the previous strobe. Until then it holds.
- R5: mute_l / mute_r set that channel's goal to 255. The applied code then follows the current mode, and with zc_mode=0 muting never lowers the applied code. Clearing the mute returns to the target the same way.
- R6: pwr_down drives both applied codes to 255 in the next cycle, whatever the mode. After release, the channels return to their targets according to the mode.
- R7: With no_auto_mute=0, the 512th consecutive zero sample (at frame strobes) on a channel makes that channel's goal 255.
- R8: With no_auto_mute=1, runs of zero samples of any length leave the applied code unchanged.
- R9: A nonzero sample at a frame strobe clears that channel's zero run and releases auto-mute. The channel then returns to its target by ramp or by zero-crossing jump according to zc_mode.
- R10: The channels are independent. A target, mute, zero run or crossing on one channel does not change the other channel's applied code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle pulse per audio frame; samples valid with it |
| smp_l | input | 16 | Left sample, two's complement |
| smp_r | input | 16 | Right sample, two's complement |
| tgt_att_l | input | 8 | Left target attenuation, 0.5 dB units |
| tgt_att_r | input | 8 | Right target attenuation, 0.5 dB units |
| mute_l | input | 1 | Force left channel to full mute |
| mute_r | input | 1 | Force right channel to full mute |
| pwr_down | input | 1 | Stop output: both channels to full mute at once |
| zc_mode | input | 1 | 0: paced ramp, 1: jump at zero crossing |
| no_auto_mute | input | 1 | 1 disables muting on zero runs |
| rate_sel | input | 2 | Ramp pace code (0:8, 1:4, 2:16, 3:32 strobes/step) |
| att_l | output | 8 | Applied left attenuation code |
| att_r | output | 8 | Applied right attenuation code |

## Verification
The ramp is driven with each of the four rate codes, both upward and downward. Sampling one strobe before and one strobe after each expected step separates a wrong rate decode from an off-by-one in the pace counter. Zero-crossing mode is fed with samples of constant sign, then a sign flip, then an exact zero, which tells a true crossing detector apart from one that jumps on any strobe. Zero runs of exactly 512 and 513 samples, with the disable bit set and clear, locate the auto-mute threshold. A recovery through both modes afterwards shows that the run counter clears. Mute, power-down and the per-channel stimuli are applied to one channel while the other is watched, to expose leakage between the channels.

// File: rtl/svc_pkg.sv
package svc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RAMP    = 2'd1,
        ST_WAIT_ZC = 2'd2
    } chan_st_t;

    // frame strobes per 0.5 dB step for each pace code
    function automatic logic [5:0] frames_per_step(input logic [1:0] code);
        logic [5:0] n;
        unique case (code)
            2'd0: n = 6'd8;
            2'd1: n = 6'd4;
            2'd2: n = 6'd16;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/svc_pace.sv
module svc_pace
    import svc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [5:0] cnt;
    logic [5:0] last;

    assign last = frames_per_step(rate) - 6'd1;
    assign tick = adv && (cnt >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || tick)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 6'd1;
    end
endmodule

// File: rtl/svc_zdet.sv
module svc_zdet #(
    parameter int SAMP_W   = 16,
    parameter int ZRUN_LEN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [SAMP_W-1:0] smp,
    input  logic              auto_off,
    output logic              zc,
    output logic              auto_mute
);
    localparam int CNT_W = $clog2(ZRUN_LEN + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(ZRUN_LEN);

    logic [CNT_W-1:0] run_cnt;
    logic             prev_neg;
    logic             is_zero;

    assign is_zero   = (smp == '0);
    assign zc        = is_zero || (smp[SAMP_W-1] != prev_neg);
    assign auto_mute = !auto_off && (run_cnt == RUN_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            prev_neg <= 1'b0;
        end else if (stb) begin
            prev_neg <= smp[SAMP_W-1];
            if (!is_zero)
                run_cnt <= '0;
            else if (run_cnt != RUN_MAX)
                run_cnt <= run_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/svc_chan.sv
module svc_chan
    import svc_pkg::*;
#(
    parameter int ATT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             zc,
    input  logic             zc_mode,
    input  logic [1:0]       rate,
    input  logic [ATT_W-1:0] target,
    input  logic             force_mute,
    input  logic             pd,
    output logic [ATT_W-1:0] att
);
    localparam logic [ATT_W-1:0] MUTE_CODE = '1;

    chan_st_t         state, nxt;
    logic [ATT_W-1:0] goal;
    logic             at_goal;
    logic             tick;
    logic             jump;

    assign goal    = (pd || force_mute) ? MUTE_CODE : target;
    assign at_goal = (att == goal);
    assign jump    = zc_mode && stb && zc;

    svc_pace u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_RAMP),
        .adv   (stb && (state == ST_RAMP) && !zc_mode),
        .rate  (rate),
        .tick  (tick)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:
                if (!pd && !at_goal)
                    nxt = zc_mode ? ST_WAIT_ZC : ST_RAMP;
            ST_RAMP:
                if (pd || at_goal)
                    nxt = ST_IDLE;
                else if (zc_mode)
                    nxt = ST_WAIT_ZC;
            ST_WAIT_ZC:
                if (pd || at_goal || jump)
                    nxt = ST_IDLE;
                else if (!zc_mode)
                    nxt = ST_RAMP;
            default:
                nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att <= '0;
        end else if (pd) begin
            att <= MUTE_CODE;
        end else begin
            unique case (state)
                ST_RAMP:
                    if (tick && !at_goal)
                        att <= (att < goal) ? att + ATT_W'(1) : att - ATT_W'(1);
                ST_WAIT_ZC:
                    if (jump)
                        att <= goal;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/softvol_ctrl.sv
module softvol_ctrl #(
    parameter int ATT_W    = 8,
    parameter int SAMP_W   = 16,
    parameter int ZRUN_LEN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [SAMP_W-1:0] smp_l,
    input  logic [SAMP_W-1:0] smp_r,
    input  logic [ATT_W-1:0]  tgt_att_l,
    input  logic [ATT_W-1:0]  tgt_att_r,
    input  logic              mute_l,
    input  logic              mute_r,
    input  logic              pwr_down,
    input  logic              zc_mode,
    input  logic              no_auto_mute,
    input  logic [1:0]        rate_sel,
    output logic [ATT_W-1:0]  att_l,
    output logic [ATT_W-1:0]  att_r
);
    localparam int NCH = 2;

    logic [NCH-1:0][SAMP_W-1:0] smp;
    logic [NCH-1:0][ATT_W-1:0]  tgt;
    logic [NCH-1:0][ATT_W-1:0]  att;
    logic [NCH-1:0]             mute_in;

    assign smp     = {smp_r, smp_l};
    assign tgt     = {tgt_att_r, tgt_att_l};
    assign mute_in = {mute_r, mute_l};
    assign att_l   = att[0];
    assign att_r   = att[1];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic zc;
        logic auto_mute;

        svc_zdet #(.SAMP_W(SAMP_W), .ZRUN_LEN(ZRUN_LEN)) u_zdet (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb       (frame_stb),
            .smp       (smp[ch]),
            .auto_off  (no_auto_mute),
            .zc        (zc),
            .auto_mute (auto_mute)
        );

        svc_chan #(.ATT_W(ATT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .stb        (frame_stb),
            .zc         (zc),
            .zc_mode    (zc_mode),
            .rate       (rate_sel),
            .target     (tgt[ch]),
            .force_mute (mute_in[ch] || auto_mute),
            .pd         (pwr_down),
            .att        (att[ch])
        );
    end
endmodule

// File: rtl/softvol_ctrl_chk.sv
module softvol_ctrl_chk #(
    parameter int ATT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_stb,
    input logic             mute_l,
    input logic             pwr_down,
    input logic             zc_mode,
    input logic [ATT_W-1:0] att_l,
    input logic [ATT_W-1:0] att_r
);
    localparam logic [ATT_W-1:0] MUTE_CODE = '1;

    AST_PD_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (att_l == MUTE_CODE && att_r == MUTE_CODE)); // R6

    AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(zc_mode) && !$past(pwr_down)) |->
        (att_l == $past(att_l) || att_l == $past(att_l) + ATT_W'(1)
         || att_l + ATT_W'(1) == $past(att_l))); // R2

    AST_CHANGE_ON_STROBE_L: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_stb) && !$past(pwr_down)) |-> $stable(att_l)); // R4

    AST_CHANGE_ON_STROBE_R: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_stb) && !$past(pwr_down)) |-> $stable(att_r)); // R10

    AST_MUTE_NEVER_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mute_l) && !$past(zc_mode) && !$past(pwr_down)) |->
        (att_l >= $past(att_l))); // R5
endmodule

bind softvol_ctrl softvol_ctrl_chk #(.ATT_W(ATT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .mute_l    (mute_l),
    .pwr_down  (pwr_down),
    .zc_mode   (zc_mode),
    .att_l     (att_l),
    .att_r     (att_r)
);

// File: tb/softvol_ctrl_test.sv
module softvol_ctrl_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_stb = 1'b0;
    logic signed [15:0] smp_l = 16'sd1000;
    logic signed [15:0] smp_r = 16'sd1000;
    logic [7:0]         tgt_att_l = 8'd0;
    logic [7:0]         tgt_att_r = 8'd0;
    logic               mute_l = 1'b0;
    logic               mute_r = 1'b0;
    logic               pwr_down = 1'b0;
    logic               zc_mode = 1'b0;
    logic               no_auto_mute = 1'b0;
    logic [1:0]         rate_sel = 2'd0;
    logic [7:0]         att_l, att_r;

    int checks = 0;
    int errors = 0;
    int cur = 0;

    always #2.5 clk = ~clk;

    softvol_ctrl uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .smp_l(smp_l), .smp_r(smp_r),
        .tgt_att_l(tgt_att_l), .tgt_att_r(tgt_att_r),
        .mute_l(mute_l), .mute_r(mute_r), .pwr_down(pwr_down),
        .zc_mode(zc_mode), .no_auto_mute(no_auto_mute), .rate_sel(rate_sel),
        .att_l(att_l), .att_r(att_r)
    );

    // frame strobe: one cycle high out of four
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            frame_stb = 1'b1;
            @(negedge clk);
            frame_stb = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // returns at the negedge after the n-th strobe edge
    task automatic wait_strobes(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!frame_stb);
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 reset att_l", att_l, 0);
        check("R1 reset att_r", att_r, 0);
    endtask

    task automatic t_rate(input logic [1:0] code, input int per, input int dir);
        int start;
        start = cur;
        rate_sel = code;
        zc_mode = 1'b0;
        tgt_att_l = 8'(start + 2 * dir);
        tgt_att_r = 8'(start + 2 * dir);
        wait_strobes(per - 1);
        check("R3 before first step", att_l, start);
        wait_strobes(1);
        check("R3 first step", att_l, start + dir);
        check("R2 unit step right", att_r, start + dir);
        wait_strobes(per);
        check("R3 second step", att_l, start + 2 * dir);
        wait_strobes(per);
        check("R2 holds at goal", att_l, start + 2 * dir);
        cur = start + 2 * dir;
    endtask

    task automatic t_zero_cross;
        zc_mode = 1'b1;
        tgt_att_l = 8'd40;
        tgt_att_r = 8'd7;
        smp_r = 16'sd500;
        wait_strobes(3);
        check("R4 no crossing holds L", att_l, cur);
        check("R4 no crossing holds R", att_r, cur);
        smp_r = -16'sd500;
        wait_strobes(1);
        check("R4 sign flip jumps R", att_r, 7);
        check("R10 L unaffected by R crossing", att_l, cur);
        smp_l = 16'sd0;
        wait_strobes(1);
        check("R4 zero sample jumps L", att_l, 40);
    endtask

    task automatic t_mute_ramp;
        tgt_att_l = 8'd250;
        smp_l = -16'sd1000;
        wait_strobes(1);
        check("R4 jump to 250", att_l, 250);
        zc_mode = 1'b0;
        rate_sel = 2'd1;
        mute_l = 1'b1;
        wait_strobes(19);
        check("R5 mute ramp step 4", att_l, 254);
        wait_strobes(1);
        check("R5 mute reaches 255", att_l, 255);
        check("R10 right not muted", att_r, 7);
        mute_l = 1'b0;
        wait_strobes(20);
        check("R5 unmute ramps back", att_l, 250);
    endtask

    task automatic t_power_down;
        zc_mode = 1'b1;
        smp_r = -16'sd1000;
        wait_strobes(1);
        pwr_down = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R6 pd left muted", att_l, 255);
        check("R6 pd right muted", att_r, 255);
        wait_strobes(2);
        check("R6 pd holds", att_l, 255);
        pwr_down = 1'b0;
        wait_strobes(2);
        check("R6 release waits for crossing", att_r, 255);
        smp_l = 16'sd1000;
        smp_r = 16'sd1000;
        wait_strobes(1);
        check("R6 release left", att_l, 250);
        check("R6 release right", att_r, 7);
    endtask

    task automatic t_auto_mute_zc;
        no_auto_mute = 1'b0;
        smp_l = 16'sd0;
        wait_strobes(512);
        check("R7 512th zero only arms", att_l, 250);
        wait_strobes(1);
        check("R7 auto-mute applied", att_l, 255);
        check("R10 right unaffected", att_r, 7);
        smp_l = 16'sd1000;
        wait_strobes(1);
        check("R9 release waits for crossing", att_l, 255);
        smp_l = -16'sd1000;
        wait_strobes(1);
        check("R9 released at crossing", att_l, 250);
    endtask

    task automatic t_no_auto_mute;
        no_auto_mute = 1'b1;
        smp_l = 16'sd0;
        wait_strobes(600);
        check("R8 long zero run ignored", att_l, 250);
        smp_l = 16'sd1000;
        wait_strobes(1);
        no_auto_mute = 1'b0;
    endtask

    task automatic t_auto_mute_ramp;
        zc_mode = 1'b0;
        rate_sel = 2'd1;
        smp_l = 16'sd0;
        wait_strobes(512);
        check("R7 ramp mode threshold", att_l, 250);
        wait_strobes(4);
        check("R7 ramp toward mute", att_l, 251);
        smp_l = 16'sd1000;
        wait_strobes(1);
        check("R9 run cleared", att_l, 251);
        wait_strobes(3);
        check("R9 ramp back to target", att_l, 250);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wait_strobes(1);
        t_reset();
        t_rate(2'd1, 4, 1);
        t_rate(2'd0, 8, 1);
        t_rate(2'd2, 16, 1);
        t_rate(2'd3, 32, 1);
        t_rate(2'd1, 4, -1);
        t_zero_cross();
        t_mute_ramp();
        t_power_down();
        t_auto_mute_zc();
        t_no_auto_mute();
        t_auto_mute_ramp();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule